// File: doc/BRIEF.md
# Memory-Side Request Issue Arbiter

This block decides which request a cache controller sends next to the memory-side bus. Every cycle it sees up to three sources: the oldest pending entry of the miss queue, the oldest pending entry of the write buffer, and an optional prefetch request. It also sees the write buffer's full flag and in-service count, the miss queue's full flag, and one search result from each queue. Each search result is a pending entry that the owning queue found while looking for an address clash with the other side's candidate. The arbiter checks the clash itself, from the address and size, before it acts on a search result.

Misses normally go first. When the write buffer is full and has no entry in flight, writes take priority, except that an older miss whose range overlaps the write is still served ahead of it. When write priority is not in force, a pending writeback that overlaps the chosen miss is always sent before that miss, so that dirty data reaches memory first. A prefetch is granted only when both queues are idle and the miss queue has room. The grant leaves the block as a combinational one-hot vector with an entry index. A registered copy follows one cycle later, together with the bus command and a flag that says whether a new bus request must be raised.

Top module: `arb_issue`

## Requirements
- R1: When only the miss candidate is valid, the grant is miss (gnt bit 0) with miss_idx. When only the write candidate is valid, the grant is write (gnt bit 1) with wb_idx.
- R2: When both candidates are valid and write priority is not in force, the miss is granted, unless R5 applies. Write priority is not in force when wb_full is low or wb_busy is nonzero.
- R3: When both candidates are valid, wb_full is high and wb_busy is zero, the write is granted with wb_idx, unless R4 applies. The write-buffer search result is ignored in this case.
- R4: Under write priority, when the miss search result is valid, overlaps the write candidate and carries a strictly smaller order stamp (unsigned) than wb_ord, the grant is miss with mhit_idx. An equal or larger stamp, or no overlap, leaves the write granted.
- R5: Without write priority, when the write search result is valid and overlaps the miss candidate, the grant is write with whit_idx.
- R6: Two requests overlap when the half-open byte ranges [addr, addr+size) intersect. Ranges that only touch do not overlap, and a size of zero never overlaps.
- R7: When neither queue candidate is valid, a valid prefetch is granted (gnt bit 2) with pf_idx, but only while mq_full is low. A prefetch is never granted while either queue candidate is valid.
- R8: When nothing is eligible, gnt_o and gidx_o are zero.
- R9: The registered command is 4 (write) for a write grant. For a miss or prefetch grant, the attribute bits are {exclusive=bit2, line valid=bit1, line writable=bit0}: the command is 3 (upgrade) when the line is valid and not writable, otherwise 2 (read-exclusive) when exclusive is set, otherwise 1 (read). It is 0 with no grant.
- R10: gnt_q and gidx_q equal the previous cycle's gnt_o and gidx_o. breq_q is high for a miss or write grant and low for a prefetch grant or no grant.
- R11: While rst_n is low, gnt_q, gidx_q, cmd_q and breq_q are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| miss_vld | input | 1 | Oldest pending miss is present |
| miss_idx | input | IDX_W | Miss queue index of that entry |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_size | input | SIZE_W | Byte length of the miss |
| miss_ord | input | ORD_W | Order stamp of the miss |
| miss_attr | input | 3 | {exclusive, line valid, line writable} |
| wb_vld | input | 1 | Oldest pending write is present |
| wb_idx | input | IDX_W | Write buffer index |
| wb_addr | input | ADDR_W | Byte address of the write |
| wb_size | input | SIZE_W | Byte length of the write |
| wb_ord | input | ORD_W | Order stamp of the write |
| wb_full | input | 1 | Write buffer full |
| wb_busy | input | BUSY_W | Write entries in service |
| mhit_vld | input | 1 | Miss queue search result present |
| mhit_idx | input | IDX_W | Index of that miss entry |
| mhit_addr | input | ADDR_W | Its address |
| mhit_size | input | SIZE_W | Its length |
| mhit_ord | input | ORD_W | Its order stamp |
| mhit_attr | input | 3 | Its attribute bits |
| whit_vld | input | 1 | Write buffer search result present |
| whit_idx | input | IDX_W | Index of that write entry |
| whit_addr | input | ADDR_W | Its address |
| whit_size | input | SIZE_W | Its length |
| mq_full | input | 1 | Miss queue full |
| pf_vld | input | 1 | Prefetch request present |
| pf_idx | input | IDX_W | Slot for the prefetch fill |
| pf_attr | input | 3 | Prefetch attribute bits |
| gnt_o | output | 3 | One-hot grant {prefetch, write, miss} |
| gidx_o | output | IDX_W | Granted entry index |
| gnt_q | output | 3 | Registered grant |
| gidx_q | output | IDX_W | Registered index |
| cmd_q | output | 3 | Registered bus command |
| breq_q | output | 1 | Registered new-bus-request flag |

## Verification
A table walks each combination of pending queues, write-buffer full and busy state, present search results and prefetch state. It separates plain miss priority from write priority, and it separates write priority broken by an older overlapping miss from write priority that holds against a newer or disjoint miss. It also covers a write-buffer clash that must be ignored under write priority. Directed cases probe the overlap edges (touching ranges, a one-byte intersection, zero size) and equal order stamps. Each attribute pattern that selects a different command, and the registered copy during and after reset, are checked as well.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_READ  = 3'd1,
        CMD_READX = 3'd2,
        CMD_UPGR  = 3'd3,
        CMD_WRITE = 3'd4
    } cmd_e;

    localparam int G_MISS = 0;
    localparam int G_WB   = 1;
    localparam int G_PF   = 2;
    localparam int GNT_W  = 3;

    localparam int A_WR   = 0;
    localparam int A_LV   = 1;
    localparam int A_EX   = 2;
    localparam int ATTR_W = 3;
endpackage

// File: rtl/arb_overlap.sv
module arb_overlap #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 7
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [SIZE_W-1:0] b_size,
    output logic              hit
);
    localparam int EW  = ADDR_W + 1;
    localparam int PAD = EW - SIZE_W;

    logic [EW-1:0] a_lo, b_lo, a_hi, b_hi;

    always_comb begin
        a_lo = {1'b0, a_addr};
        b_lo = {1'b0, b_addr};
        a_hi = a_lo + {{PAD{1'b0}}, a_size};
        b_hi = b_lo + {{PAD{1'b0}}, b_size};
        hit  = (a_size != '0) && (b_size != '0) && (a_lo < b_hi) && (b_lo < a_hi);
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int ORD_W  = 8,
    parameter int BUSY_W = 3
) (
    input  logic              miss_vld,
    input  logic [IDX_W-1:0]  miss_idx,
    input  logic [ORD_W-1:0]  miss_ord,
    input  logic [ATTR_W-1:0] miss_attr,
    input  logic              wb_vld,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [ORD_W-1:0]  wb_ord,
    input  logic              wb_full,
    input  logic [BUSY_W-1:0] wb_busy,
    input  logic              mhit_vld,
    input  logic              mhit_ovl,
    input  logic [IDX_W-1:0]  mhit_idx,
    input  logic [ORD_W-1:0]  mhit_ord,
    input  logic [ATTR_W-1:0] mhit_attr,
    input  logic              whit_vld,
    input  logic              whit_ovl,
    input  logic [IDX_W-1:0]  whit_idx,
    input  logic              mq_full,
    input  logic              pf_vld,
    input  logic [IDX_W-1:0]  pf_idx,
    input  logic [ATTR_W-1:0] pf_attr,
    output logic [GNT_W-1:0]  sel_gnt,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [ATTR_W-1:0] sel_attr
);
    logic wr_prio, miss_first, wb_first;

    always_comb begin
        wr_prio    = wb_full && (wb_busy == '0);
        miss_first = mhit_vld && mhit_ovl && (mhit_ord < wb_ord);
        wb_first   = whit_vld && whit_ovl;
        sel_gnt    = '0;
        sel_idx    = '0;
        sel_attr   = '0;
        if (miss_vld && !wb_vld) begin
            sel_gnt[G_MISS] = 1'b1;
            sel_idx         = miss_idx;
            sel_attr        = miss_attr;
        end else if (wb_vld && !miss_vld) begin
            sel_gnt[G_WB] = 1'b1;
            sel_idx       = wb_idx;
        end else if (wb_vld && miss_vld) begin
            if (wr_prio) begin
                if (miss_first) begin
                    sel_gnt[G_MISS] = 1'b1;
                    sel_idx         = mhit_idx;
                    sel_attr        = mhit_attr;
                end else begin
                    sel_gnt[G_WB] = 1'b1;
                    sel_idx       = wb_idx;
                end
            end else if (wb_first) begin
                sel_gnt[G_WB] = 1'b1;
                sel_idx       = whit_idx;
            end else begin
                sel_gnt[G_MISS] = 1'b1;
                sel_idx         = miss_idx;
                sel_attr        = miss_attr;
            end
        end else if (pf_vld && !mq_full) begin
            sel_gnt[G_PF] = 1'b1;
            sel_idx       = pf_idx;
            sel_attr      = pf_attr;
        end
    end

    logic unused_ord;
    assign unused_ord = ^miss_ord;
endmodule

// File: rtl/arb_fill_cmd.sv
module arb_fill_cmd
    import arb_pkg::*;
(
    input  logic [GNT_W-1:0]  gnt,
    input  logic [ATTR_W-1:0] attr,
    output cmd_e              cmd
);
    always_comb begin
        if (gnt[G_WB]) begin
            cmd = CMD_WRITE;
        end else if (gnt[G_MISS] || gnt[G_PF]) begin
            if (attr[A_LV] && !attr[A_WR]) cmd = CMD_UPGR;
            else if (attr[A_EX])           cmd = CMD_READX;
            else                           cmd = CMD_READ;
        end else begin
            cmd = CMD_NONE;
        end
    end
endmodule

// File: rtl/arb_issue.sv
module arb_issue
    import arb_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 7,
    parameter int ORD_W  = 8,
    parameter int BUSY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_vld,
    input  logic [IDX_W-1:0]  miss_idx,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [SIZE_W-1:0] miss_size,
    input  logic [ORD_W-1:0]  miss_ord,
    input  logic [2:0]        miss_attr,
    input  logic              wb_vld,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [SIZE_W-1:0] wb_size,
    input  logic [ORD_W-1:0]  wb_ord,
    input  logic              wb_full,
    input  logic [BUSY_W-1:0] wb_busy,
    input  logic              mhit_vld,
    input  logic [IDX_W-1:0]  mhit_idx,
    input  logic [ADDR_W-1:0] mhit_addr,
    input  logic [SIZE_W-1:0] mhit_size,
    input  logic [ORD_W-1:0]  mhit_ord,
    input  logic [2:0]        mhit_attr,
    input  logic              whit_vld,
    input  logic [IDX_W-1:0]  whit_idx,
    input  logic [ADDR_W-1:0] whit_addr,
    input  logic [SIZE_W-1:0] whit_size,
    input  logic              mq_full,
    input  logic              pf_vld,
    input  logic [IDX_W-1:0]  pf_idx,
    input  logic [2:0]        pf_attr,
    output logic [2:0]        gnt_o,
    output logic [IDX_W-1:0]  gidx_o,
    output logic [2:0]        gnt_q,
    output logic [IDX_W-1:0]  gidx_q,
    output logic [2:0]        cmd_q,
    output logic              breq_q
);
    typedef struct packed {
        logic [GNT_W-1:0] gnt;
        logic [IDX_W-1:0] idx;
        cmd_e             cmd;
        logic             breq;
    } st_t;

    st_t st_d, st_q;

    logic              mhit_ovl, whit_ovl;
    logic [GNT_W-1:0]  sel_gnt;
    logic [IDX_W-1:0]  sel_idx;
    logic [ATTR_W-1:0] sel_attr;
    cmd_e              sel_cmd;

    // R6: clash checks for the two search results
    arb_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl_m (
        .a_addr(mhit_addr), .a_size(mhit_size),
        .b_addr(wb_addr),   .b_size(wb_size),
        .hit(mhit_ovl)
    );
    arb_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl_w (
        .a_addr(whit_addr), .a_size(whit_size),
        .b_addr(miss_addr), .b_size(miss_size),
        .hit(whit_ovl)
    );

    arb_pick #(.IDX_W(IDX_W), .ORD_W(ORD_W), .BUSY_W(BUSY_W)) u_pick (
        .miss_vld(miss_vld), .miss_idx(miss_idx), .miss_ord(miss_ord), .miss_attr(miss_attr),
        .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_ord(wb_ord),
        .wb_full(wb_full), .wb_busy(wb_busy),
        .mhit_vld(mhit_vld), .mhit_ovl(mhit_ovl), .mhit_idx(mhit_idx),
        .mhit_ord(mhit_ord), .mhit_attr(mhit_attr),
        .whit_vld(whit_vld), .whit_ovl(whit_ovl), .whit_idx(whit_idx),
        .mq_full(mq_full), .pf_vld(pf_vld), .pf_idx(pf_idx), .pf_attr(pf_attr),
        .sel_gnt(sel_gnt), .sel_idx(sel_idx), .sel_attr(sel_attr)
    );

    arb_fill_cmd u_cmd (
        .gnt(sel_gnt), .attr(sel_attr), .cmd(sel_cmd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gnt  = sel_gnt;
        st_d.idx  = sel_idx;
        st_d.cmd  = sel_cmd;
        st_d.breq = sel_gnt[G_MISS] || sel_gnt[G_WB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{gnt: '0, idx: '0, cmd: CMD_NONE, breq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o  = sel_gnt;
    assign gidx_o = sel_idx;
    assign gnt_q  = st_q.gnt;
    assign gidx_q = st_q.idx;
    assign cmd_q  = st_q.cmd;
    assign breq_q = st_q.breq;

    a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    a_r7_no_pf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        mq_full |-> !gnt_o[G_PF]);

    a_r7_no_pf_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_vld || wb_vld) |-> !gnt_o[G_PF]);

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_vld || wb_vld || pf_vld) |-> (gnt_o == '0));

    a_r10_reg_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (gnt_q == $past(gnt_o)) && (gidx_q == $past(gidx_o)));

    a_r9_write_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_q[G_WB] |-> (cmd_q == CMD_WRITE));

    a_r10_pf_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_q[G_PF] |-> !breq_q);
endmodule

// File: tb/sim_arb_issue.sv
module sim_arb_issue;
    localparam int IW = 3, AW = 16, SW = 7, OW = 8, CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          miss_vld, wb_vld, wb_full, mhit_vld, whit_vld, mq_full, pf_vld;
    logic [IW-1:0] miss_idx, wb_idx, mhit_idx, whit_idx, pf_idx;
    logic [AW-1:0] miss_addr, wb_addr, mhit_addr, whit_addr;
    logic [SW-1:0] miss_size, wb_size, mhit_size, whit_size;
    logic [OW-1:0] miss_ord, wb_ord, mhit_ord;
    logic [2:0]    miss_attr, mhit_attr, pf_attr;
    logic [CW-1:0] wb_busy;
    logic [2:0]    gnt_o, gnt_q, cmd_q;
    logic [IW-1:0] gidx_o, gidx_q;
    logic          breq_q;

    arb_issue u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_vld(miss_vld), .miss_idx(miss_idx), .miss_addr(miss_addr), .miss_size(miss_size),
        .miss_ord(miss_ord), .miss_attr(miss_attr),
        .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_addr(wb_addr), .wb_size(wb_size), .wb_ord(wb_ord),
        .wb_full(wb_full), .wb_busy(wb_busy),
        .mhit_vld(mhit_vld), .mhit_idx(mhit_idx), .mhit_addr(mhit_addr), .mhit_size(mhit_size),
        .mhit_ord(mhit_ord), .mhit_attr(mhit_attr),
        .whit_vld(whit_vld), .whit_idx(whit_idx), .whit_addr(whit_addr), .whit_size(whit_size),
        .mq_full(mq_full), .pf_vld(pf_vld), .pf_idx(pf_idx), .pf_attr(pf_attr),
        .gnt_o(gnt_o), .gidx_o(gidx_o), .gnt_q(gnt_q), .gidx_q(gidx_q),
        .cmd_q(cmd_q), .breq_q(breq_q)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // row: {req[3:0], mv, wv, full, busy[1:0], mhv, mh_old, mh_ovl, whv, wh_ovl, pfv, mqf, gnt[2:0], idx[2:0]}
    localparam int NV = 17;
    localparam logic [21:0] TBL [NV] = '{
        {4'd1, 1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b001,3'd1}, // R1 miss only
        {4'd1, 1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b010,3'd2}, // R1 write only
        {4'd2, 1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b001,3'd1}, // R2 both
        {4'd2, 1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b001,3'd1}, // R2 full but busy
        {4'd3, 1'b1,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b010,3'd2}, // R3 full and idle
        {4'd4, 1'b1,1'b1,1'b1,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 3'b001,3'd3}, // R4 older clash
        {4'd4, 1'b1,1'b1,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 3'b010,3'd2}, // R4 newer clash
        {4'd4, 1'b1,1'b1,1'b1,2'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b010,3'd2}, // R4 older disjoint
        {4'd5, 1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 3'b010,3'd4}, // R5 wb clash
        {4'd5, 1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b001,3'd1}, // R5 wb disjoint
        {4'd5, 1'b1,1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 3'b010,3'd4}, // R5 full busy clash
        {4'd3, 1'b1,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 3'b010,3'd2}, // R3 wb search ignored
        {4'd7, 1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'b100,3'd5}, // R7 prefetch
        {4'd7, 1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 3'b000,3'd0}, // R7 mq full
        {4'd7, 1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'b001,3'd1}, // R7 pf behind miss
        {4'd8, 1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,3'd0}, // R8 idle
        {4'd7, 1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'b010,3'd2}  // R7 pf behind write
    };

    // expected command from the granted slot (R9): miss attr 100, mhit attr 010, pf attr 000
    function automatic int exp_cmd(input logic [2:0] idx);
        case (idx)
            3'd1: return 2;
            3'd3: return 3;
            3'd2, 3'd4: return 4;
            3'd5: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic base();
        miss_vld = 0; wb_vld = 0; mhit_vld = 0; whit_vld = 0; pf_vld = 0;
        wb_full = 0; wb_busy = '0; mq_full = 0;
        miss_idx = 3'd1; wb_idx = 3'd2; mhit_idx = 3'd3; whit_idx = 3'd4; pf_idx = 3'd5;
        miss_addr = 16'h0100; miss_size = 7'd16; miss_ord = 8'd40; miss_attr = 3'b100;
        wb_addr = 16'h0200; wb_size = 7'd32; wb_ord = 8'd20;
        mhit_addr = 16'h0300; mhit_size = 7'd8; mhit_ord = 8'd30; mhit_attr = 3'b010;
        whit_addr = 16'h0180; whit_size = 7'd8; pf_attr = 3'b000;
    endtask

    task automatic prio_clash(input logic [15:0] a, input logic [6:0] s, input logic [7:0] o,
                              input logic [2:0] eg, input logic [2:0] ei, input string req);
        @(negedge clk);
        base();
        miss_vld = 1; wb_vld = 1; wb_full = 1; mhit_vld = 1;
        mhit_addr = a; mhit_size = s; mhit_ord = o;
        #1;
        chk(gnt_o == eg && gidx_o == ei, req, {gnt_o, gidx_o}, {eg, ei});
    endtask

    task automatic cmd_case(input logic [2:0] attr, input int ec, input string req);
        @(negedge clk);
        base();
        miss_vld = 1; miss_attr = attr;
        @(posedge clk); #1;
        chk(cmd_q == 3'(ec), req, cmd_q, ec);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        base();
        miss_vld = 1;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset holds registered outputs low
        chk(gnt_q == 0 && gidx_q == 0, "R11 grant in reset", {gnt_q, gidx_q}, 0);
        chk(cmd_q == 0 && breq_q == 0, "R11 cmd in reset", {cmd_q, breq_q}, 0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = TBL[i];
            @(negedge clk);
            base();
            miss_vld = v[17]; wb_vld = v[16]; wb_full = v[15]; wb_busy = {1'b0, v[14:13]};
            mhit_vld = v[12]; mhit_ord = v[11] ? 8'd10 : 8'd30;
            mhit_addr = v[10] ? 16'h0210 : 16'h0300;
            whit_vld = v[9]; whit_addr = v[8] ? 16'h0108 : 16'h0180;
            pf_vld = v[7]; mq_full = v[6];
            #1;
            chk(gnt_o == v[5:3], $sformatf("R%0d row %0d grant", v[21:18], i), gnt_o, v[5:3]);
            chk(gidx_o == v[2:0], $sformatf("R%0d row %0d index", v[21:18], i), gidx_o, v[2:0]);
            @(posedge clk); #1;
            // R10 and R9: registered copy, request flag and command
            chk(gnt_q == v[5:3] && gidx_q == v[2:0], $sformatf("R10 row %0d reg", i),
                {gnt_q, gidx_q}, v[5:0]);
            chk(breq_q == (v[3] | v[4]), $sformatf("R10 row %0d breq", i), breq_q, v[3] | v[4]);
            chk(cmd_q == 3'(exp_cmd(v[2:0])), $sformatf("R9 row %0d cmd", i), cmd_q, exp_cmd(v[2:0]));
        end

        // R6: boundaries against write range [0x200,0x220)
        prio_clash(16'h0220, 7'd8, 8'd10, 3'b010, 3'd2, "R6 touch above");
        prio_clash(16'h01F8, 7'd8, 8'd10, 3'b010, 3'd2, "R6 touch below");
        prio_clash(16'h01F8, 7'd9, 8'd10, 3'b001, 3'd3, "R6 one byte");
        prio_clash(16'h021F, 7'd1, 8'd10, 3'b001, 3'd3, "R6 last byte");
        prio_clash(16'h0208, 7'd0, 8'd10, 3'b010, 3'd2, "R6 zero size");
        // R4: equal stamp is not older
        prio_clash(16'h0208, 7'd4, 8'd20, 3'b010, 3'd2, "R4 equal stamp");
        prio_clash(16'h0208, 7'd4, 8'd19, 3'b001, 3'd3, "R4 one older");

        // R9: attribute patterns
        cmd_case(3'b110, 3, "R9 excl valid ro -> upgrade");
        cmd_case(3'b010, 3, "R9 valid ro -> upgrade");
        cmd_case(3'b111, 2, "R9 excl writable -> readx");
        cmd_case(3'b101, 2, "R9 excl invalid -> readx");
        cmd_case(3'b001, 1, "R9 invalid -> read");
        cmd_case(3'b011, 1, "R9 valid writable -> read");

        // R11: reset during activity
        @(negedge clk);
        base();
        wb_vld = 1;
        rst_n = 0;
        #1;
        chk(gnt_q == 0 && breq_q == 0 && cmd_q == 0, "R11 async clear", {gnt_q, cmd_q, breq_q}, 0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        chk(gnt_q == 3'b010 && cmd_q == 3'd4, "R10 after reset", {gnt_q, cmd_q}, {3'b010, 3'd4});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule